// File: doc/BRIEF.md
# Reset and Low-Power Recovery Sequencer

This block is the state machine at the heart of a clock-and-reset controller. It turns power-on, low-voltage and external reset requests into one internal reset. It checks the quality of the oscillator before the system clock is enabled. If the crystal never settles, it falls back to an internal self clock. It also brings the chip back out of three low-power modes, and each mode has its own recovery path. All counting is done in reference clock cycles (`clk_ref`). The analog regulator and the oscillator are outside the block and are seen only through the `vreg_ready` and `osc_valid` inputs.

A power-on reset (`por_rst_n` low) clears all state and sets a status flag. Software clears that flag with a write-one strobe. While the flag stays clear after a later reset, the retained memory is known to be intact. The external reset pin is synchronised and then filtered for a minimum width. If the last clock check passed and the oscillator has not been stopped since, an external reset skips the clock check and only applies the fixed startup stretch.

A sleep request is taken only while running. Stop mode lowers the regulator and stops the oscillator, so its wake-up needs a regulator handshake and then a full clock check. Pseudo-stop needs only the regulator handshake. Doze resumes clocks on the next edge after a wake event.

Top module: `rst_wake_seq`

## Requirements
- R1: After `por_rst_n` is released, with `lvr_req` low and `ext_rst_n` high, `rst_int` stays high and `sys_clk_en` stays low while a clock check runs. The check passes once `osc_valid` has been sampled high on `CQ_PASS_CYC` consecutive edges. `rst_int` then falls and `sys_clk_en` rises `STARTUP_CYC` edges later. Counting the first edge with `por_rst_n` high as edge 1, the release edge is 1 + (check length) + `STARTUP_CYC`.
- R2: If the check has not passed by its `CQ_TIMEOUT_CYC`-th edge, `clk_sel_self` goes to 1 (self clock) and startup continues. A later passing check sets `clk_sel_self` back to 0 (crystal).
- R3: If the pass and the timeout fall on the same edge, the pass wins and `clk_sel_self` is 0.
- R4: A single low sample of `osc_valid` during a check restarts the consecutive-pass count.
- R5: An external reset that is low on `EXT_MIN_CYC` or fewer consecutive synchronised samples is ignored: `rst_int` stays 0 and `sys_clk_en` stays 1.
- R6: A qualified external reset (at least `EXT_MIN_CYC`+1 low samples) sets `rst_int`. If the oscillator was stable, no check runs, and `rst_int` falls on edge `EXT_SYNC_STAGES` + `STARTUP_CYC` + 1, counting the first edge that samples `ext_rst_n` high as edge 1. With the defaults this is 194 cycles after that edge, inside the 192 to 196 window.
- R7: A qualified external reset after a self-clock fallback runs a full clock check. `rst_int` then falls on edge `EXT_SYNC_STAGES` + 1 + `CQ_PASS_CYC` + `STARTUP_CYC` when `osc_valid` is high.
- R8: `rst_int` is high on the edge after `lvr_req` is sampled high. On release, a clock check always runs: `rst_int` falls on edge 1 + `CQ_PASS_CYC` + `STARTUP_CYC` with `osc_valid` high.
- R9: Stop mode is entered with `sleep_req` high and `sleep_mode` = 2'b01 while running. It drops `sys_clk_en` and `vreg_fpm_req` on the next edge. Only `wake_ext_irq` or `wake_periodic` wakes it, and `wake_int_irq` is ignored. A wake raises `vreg_fpm_req`. Once `vreg_ready` is sampled high, a full check runs, and `sys_clk_en` rises `CQ_PASS_CYC` edges later with `rst_int` kept low.
- R10: Pseudo-stop (`sleep_mode` = 2'b10) drops `vreg_fpm_req` and `sys_clk_en`. Any of the three wake inputs raises `vreg_fpm_req`, and `sys_clk_en` rises on the edge that samples `vreg_ready` high.
- R11: Doze (`sleep_mode` = 2'b11) keeps `vreg_fpm_req` high. Any of the three wake inputs restores `sys_clk_en` on the next edge.
- R12: `por_flag` is set only by `por_rst_n` and cleared on the edge that samples `por_flag_clr` high. Low-voltage and external resets leave it clear.
- R13: A sleep request is ignored when `sleep_mode` = 2'b00 and while any reset or check is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Oscillator reference clock; all counts are in its cycles |
| por_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| lvr_req | input | 1 | Low-voltage reset request, active high |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to the block |
| sleep_req | input | 1 | Request to enter the mode given by sleep_mode |
| sleep_mode | input | 2 | 00 none, 01 stop, 10 pseudo-stop, 11 doze |
| wake_ext_irq | input | 1 | External interrupt wake event |
| wake_periodic | input | 1 | Periodic wake timer event |
| wake_int_irq | input | 1 | Internal peripheral interrupt wake event |
| osc_valid | input | 1 | Oscillator frequency monitor reports valid oscillation |
| vreg_ready | input | 1 | Regulator reports full performance reached |
| por_flag_clr | input | 1 | Write-one-to-clear strobe for por_flag |
| rst_int | output | 1 | Internal system reset, active high |
| vreg_fpm_req | output | 1 | Request for regulator full-performance mode |
| clk_sel_self | output | 1 | 1 selects the internal self clock, 0 the crystal |
| sys_clk_en | output | 1 | System clock enable |
| por_flag | output | 1 | Set by power-on reset; memory retention indicator |

## Verification
Two events in the clock check can land on the same reference edge: the consecutive-valid count reaching its target, and the timeout counter expiring. The bench sweeps the cycle at which `osc_valid` rises through every offset from the start of the check up to the timeout. One of these offsets puts the pass exactly on the timeout edge. For each offset, the bench works out in arithmetic which of the two events comes first, the edge where `rst_int` falls, and the expected `clk_sel_self`. On the shared edge it expects the crystal to stay selected.

// File: rtl/rws_pkg.sv
package rws_pkg;

   typedef enum logic [2:0] {
      ST_HOLD    = 3'd0,
      ST_CQ      = 3'd1,
      ST_STRETCH = 3'd2,
      ST_RUN     = 3'd3,
      ST_STOP    = 3'd4,
      ST_PSTOP   = 3'd5,
      ST_DOZE    = 3'd6,
      ST_VWAIT   = 3'd7
   } rws_state_e;

   typedef enum logic [1:0] {
      LP_NONE  = 2'b00,
      LP_STOP  = 2'b01,
      LP_PSTOP = 2'b10,
      LP_DOZE  = 2'b11
   } rws_lp_e;

endpackage

// File: rtl/rws_ext_filter.sv
module rws_ext_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic pin_high,
   output logic qualified
);
   localparam int CW = $clog2(MIN_LOW_CYC + 1);

   logic          pin_s;
   logic [CW-1:0] low_cnt;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign pin_s = pin_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '1;
            end else begin
               sr[0] <= pin_n;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sr[i] <= sr[i-1];
               end
            end
         end
         assign pin_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   // count consecutive low samples, saturating at the minimum width
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (pin_s) begin
         low_cnt <= '0;
      end else if (low_cnt != CW'(MIN_LOW_CYC)) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   assign pin_high  = pin_s;
   assign qualified = !pin_s && (low_cnt == CW'(MIN_LOW_CYC));

endmodule

// File: rtl/rws_clk_check.sv
module rws_clk_check #(
   parameter int PASS_CYC    = 64,
   parameter int TIMEOUT_CYC = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic osc_valid,
   output logic pass,
   output logic expire
);
   localparam int PW = $clog2(PASS_CYC + 1);
   localparam int TW = $clog2(TIMEOUT_CYC + 1);

   logic [PW-1:0] good_cnt;
   logic [TW-1:0] age_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_cnt <= '0;
         age_cnt  <= '0;
      end else if (!run) begin
         good_cnt <= '0;
         age_cnt  <= '0;
      end else begin
         good_cnt <= osc_valid ? good_cnt + 1'b1 : '0;
         age_cnt  <= age_cnt + 1'b1;
      end
   end

   assign pass   = run && osc_valid && (good_cnt == PW'(PASS_CYC - 1));
   assign expire = run && (age_cnt == TW'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/rst_wake_seq.sv
module rst_wake_seq
   import rws_pkg::*;
#(
   parameter int CQ_PASS_CYC     = 64,
   parameter int CQ_TIMEOUT_CYC  = 4096,
   parameter int STARTUP_CYC     = 192,
   parameter int EXT_MIN_CYC     = 2,
   parameter int EXT_SYNC_STAGES = 2
) (
   input  logic       clk_ref,
   input  logic       por_rst_n,
   input  logic       lvr_req,
   input  logic       ext_rst_n,
   input  logic       sleep_req,
   input  logic [1:0] sleep_mode,
   input  logic       wake_ext_irq,
   input  logic       wake_periodic,
   input  logic       wake_int_irq,
   input  logic       osc_valid,
   input  logic       vreg_ready,
   input  logic       por_flag_clr,
   output logic       rst_int,
   output logic       vreg_fpm_req,
   output logic       clk_sel_self,
   output logic       sys_clk_en,
   output logic       por_flag
);
   localparam int SW = $clog2(STARTUP_CYC + 1);

   generate
      if (CQ_PASS_CYC < 1) begin : g_bad_pass
         $error("CQ_PASS_CYC must be at least 1");
      end
      if (CQ_TIMEOUT_CYC <= CQ_PASS_CYC) begin : g_bad_tmo
         $error("CQ_TIMEOUT_CYC must exceed CQ_PASS_CYC");
      end
      if (STARTUP_CYC < 1) begin : g_bad_start
         $error("STARTUP_CYC must be at least 1");
      end
      if (EXT_MIN_CYC < 1 || EXT_SYNC_STAGES < 0) begin : g_bad_ext
         $error("external reset filter parameters out of range");
      end
   endgenerate

   rws_state_e    st;
   logic [SW-1:0] st_cnt;
   logic          osc_ok, self_clk, from_rst, skip_cq, cq_after, flag_q;
   logic          ext_hi, ext_qual, cq_pass, cq_expire;
   logic          wake_any, wake_stop;

   rws_ext_filter #(
      .SYNC_STAGES (EXT_SYNC_STAGES),
      .MIN_LOW_CYC (EXT_MIN_CYC)
   ) u_ext (
      .clk       (clk_ref),
      .rst_n     (por_rst_n),
      .pin_n     (ext_rst_n),
      .pin_high  (ext_hi),
      .qualified (ext_qual)
   );

   rws_clk_check #(
      .PASS_CYC    (CQ_PASS_CYC),
      .TIMEOUT_CYC (CQ_TIMEOUT_CYC)
   ) u_cq (
      .clk       (clk_ref),
      .rst_n     (por_rst_n),
      .run       (st == ST_CQ),
      .osc_valid (osc_valid),
      .pass      (cq_pass),
      .expire    (cq_expire)
   );

   assign wake_stop = wake_ext_irq | wake_periodic;
   assign wake_any  = wake_stop | wake_int_irq;

   always_ff @(posedge clk_ref or negedge por_rst_n) begin
      if (!por_rst_n) begin
         st       <= ST_HOLD;
         st_cnt   <= '0;
         osc_ok   <= 1'b0;
         self_clk <= 1'b0;
         from_rst <= 1'b1;
         skip_cq  <= 1'b0;
         cq_after <= 1'b0;
         flag_q   <= 1'b1;
      end else begin
         if (por_flag_clr) flag_q <= 1'b0;
         st_cnt <= (st == ST_STRETCH) ? st_cnt + 1'b1 : '0;

         if (lvr_req) begin
            st       <= ST_HOLD;
            from_rst <= 1'b1;
            skip_cq  <= 1'b0;
            osc_ok   <= 1'b0;
         end else if (ext_qual) begin
            st       <= ST_HOLD;
            from_rst <= 1'b1;
            skip_cq  <= osc_ok;
         end else begin
            unique case (st)
               ST_HOLD: begin
                  if (ext_hi) st <= skip_cq ? ST_STRETCH : ST_CQ;
               end
               ST_CQ: begin
                  if (cq_pass) begin
                     osc_ok   <= 1'b1;
                     self_clk <= 1'b0;
                     st       <= from_rst ? ST_STRETCH : ST_RUN;
                  end else if (cq_expire) begin
                     osc_ok   <= 1'b0;
                     self_clk <= 1'b1;
                     st       <= from_rst ? ST_STRETCH : ST_RUN;
                  end
               end
               ST_STRETCH: begin
                  if (st_cnt == SW'(STARTUP_CYC - 1)) begin
                     st       <= ST_RUN;
                     from_rst <= 1'b0;
                  end
               end
               ST_RUN: begin
                  if (sleep_req) begin
                     unique case (rws_lp_e'(sleep_mode))
                        LP_STOP: begin
                           st     <= ST_STOP;
                           osc_ok <= 1'b0;
                        end
                        LP_PSTOP: st <= ST_PSTOP;
                        LP_DOZE:  st <= ST_DOZE;
                        LP_NONE:  st <= ST_RUN;
                     endcase
                  end
               end
               ST_STOP: begin
                  if (wake_stop) begin
                     st       <= ST_VWAIT;
                     cq_after <= 1'b1;
                  end
               end
               ST_PSTOP: begin
                  if (wake_any) begin
                     st       <= ST_VWAIT;
                     cq_after <= 1'b0;
                  end
               end
               ST_DOZE: begin
                  if (wake_any) st <= ST_RUN;
               end
               ST_VWAIT: begin
                  if (vreg_ready) st <= cq_after ? ST_CQ : ST_RUN;
               end
            endcase
         end
      end
   end

   assign rst_int      = (st == ST_HOLD) || (st == ST_STRETCH) || ((st == ST_CQ) && from_rst);
   assign sys_clk_en   = (st == ST_RUN);
   assign vreg_fpm_req = !((st == ST_STOP) || (st == ST_PSTOP));
   assign clk_sel_self = self_clk;
   assign por_flag     = flag_q;

endmodule

// File: rtl/rws_checker.sv
module rws_checker (
   input logic       clk_ref,
   input logic       por_rst_n,
   input logic       lvr_req,
   input logic       sleep_req,
   input logic [1:0] sleep_mode,
   input logic       por_flag_clr,
   input logic       rst_int,
   input logic       vreg_fpm_req,
   input logic       clk_sel_self,
   input logic       sys_clk_en,
   input logic       por_flag
);

   AST_RELEASE_ENABLES_CLK: assert property (@(posedge clk_ref) disable iff (!por_rst_n)
      $fell(rst_int) |-> sys_clk_en);  // R1

   AST_SEL_STABLE_IN_RUN: assert property (@(posedge clk_ref) disable iff (!por_rst_n)
      (sys_clk_en && $past(sys_clk_en)) |-> $stable(clk_sel_self));  // R2

   AST_LVR_ASSERTS_RST: assert property (@(posedge clk_ref) disable iff (!por_rst_n)
      lvr_req |=> rst_int);  // R8

   AST_SLEEP_GATES_CLK: assert property (@(posedge clk_ref) disable iff (!por_rst_n)
      (sys_clk_en && sleep_req && sleep_mode != 2'b00) |=> !sys_clk_en);  // R9

   AST_VREG_DROP_FROM_RUN: assert property (@(posedge clk_ref) disable iff (!por_rst_n)
      $fell(vreg_fpm_req) |-> $past(sys_clk_en));  // R10

   AST_DOZE_KEEPS_VREG: assert property (@(posedge clk_ref) disable iff (!por_rst_n)
      (sys_clk_en && sleep_req && sleep_mode == 2'b11) |=> vreg_fpm_req);  // R11

   AST_FLAG_NEVER_SETS: assert property (@(posedge clk_ref) disable iff (!por_rst_n)
      !por_flag |=> !por_flag);  // R12

   AST_FLAG_CLEARS: assert property (@(posedge clk_ref) disable iff (!por_rst_n)
      por_flag_clr |=> !por_flag);  // R12

endmodule

bind rst_wake_seq rws_checker u_chk (
   .clk_ref      (clk_ref),
   .por_rst_n    (por_rst_n),
   .lvr_req      (lvr_req),
   .sleep_req    (sleep_req),
   .sleep_mode   (sleep_mode),
   .por_flag_clr (por_flag_clr),
   .rst_int      (rst_int),
   .vreg_fpm_req (vreg_fpm_req),
   .clk_sel_self (clk_sel_self),
   .sys_clk_en   (sys_clk_en),
   .por_flag     (por_flag)
);

// File: tb/tb_rst_wake_seq.sv
module tb_rst_wake_seq;
   localparam int P    = 4;
   localparam int T    = 10;
   localparam int S    = 192;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       por_rst_n = 1'b0, lvr_req = 1'b0, ext_rst_n = 1'b1;
   logic       sleep_req = 1'b0;
   logic [1:0] sleep_mode = 2'b00;
   logic       wake_ext_irq = 1'b0, wake_periodic = 1'b0, wake_int_irq = 1'b0;
   logic       osc_valid = 1'b0, vreg_ready = 1'b0, por_flag_clr = 1'b0;
   logic       rst_int, vreg_fpm_req, clk_sel_self, sys_clk_en, por_flag;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   rst_wake_seq #(
      .CQ_PASS_CYC    (P),
      .CQ_TIMEOUT_CYC (T),
      .STARTUP_CYC    (S),
      .EXT_MIN_CYC    (2),
      .EXT_SYNC_STAGES(SYNC)
   ) dut (
      .clk_ref(clk), .por_rst_n(por_rst_n), .lvr_req(lvr_req), .ext_rst_n(ext_rst_n),
      .sleep_req(sleep_req), .sleep_mode(sleep_mode), .wake_ext_irq(wake_ext_irq),
      .wake_periodic(wake_periodic), .wake_int_irq(wake_int_irq), .osc_valid(osc_valid),
      .vreg_ready(vreg_ready), .por_flag_clr(por_flag_clr), .rst_int(rst_int),
      .vreg_fpm_req(vreg_fpm_req), .clk_sel_self(clk_sel_self), .sys_clk_en(sys_clk_en),
      .por_flag(por_flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int k);
      repeat (k) @(negedge clk);
   endtask

   // count negedges until rst_int has been high and then falls
   task automatic measure(input int lo_at, input int hi_at, output int n);
      bit seen = 1'b0;
      n = -1;
      for (int i = 1; i <= 2000; i++) begin
         @(negedge clk);
         if (i == lo_at) osc_valid = 1'b0;
         if (i == hi_at) osc_valid = 1'b1;
         if (rst_int) seen = 1'b1;
         if (seen && !rst_int) begin
            n = i;
            return;
         end
      end
   endtask

   task automatic do_por(input logic osc);
      por_rst_n = 1'b0;
      osc_valid = osc;
      tick(2);
      chk("R1 reset rst_int", int'(rst_int), 1);
      chk("R1 reset sys_clk_en", int'(sys_clk_en), 0);
      chk("R12 reset por_flag", int'(por_flag), 1);
      por_rst_n = 1'b1;
   endtask

   task automatic ext_pulse(input int w);
      ext_rst_n = 1'b0;
      tick(w);
      ext_rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int n;
      // R1, R2, R3: sweep the cycle at which the oscillator becomes valid
      for (int d = 0; d <= T; d++) begin
         int j;
         int self_exp;
         do_por(1'b0);
         measure(0, 1 + d, n);
         j        = (d + P <= T) ? d + P : T;
         self_exp = (d + P > T) ? 1 : 0;
         if (d + P == T) begin
            chk("R3 coincident release", n, 1 + j + S);
            chk("R3 coincident sel", int'(clk_sel_self), 0);
         end else if (self_exp == 1) begin
            chk("R2 timeout release", n, 1 + j + S);
            chk("R2 timeout sel", int'(clk_sel_self), 1);
         end else begin
            chk("R1 pass release", n, 1 + j + S);
            chk("R1 pass sel", int'(clk_sel_self), 0);
         end
         chk("R1 clock enabled", int'(sys_clk_en), 1);
      end

      // R7: after self-clock fallback, external reset runs a full check
      osc_valid = 1'b1;
      ext_pulse(3);
      measure(0, 0, n);
      chk("R7 release", n, SYNC + 1 + P + S);
      chk("R7 sel back to crystal", int'(clk_sel_self), 0);

      // R4: one low sample restarts the count
      do_por(1'b1);
      measure(P, P + 1, n);
      chk("R4 restart release", n, 1 + 2 * P + S);

      // R5, R6: external reset width sweep with stable oscillator
      for (int w = 1; w <= 5; w++) begin
         if (w <= 2) begin
            int bad = 0;
            ext_pulse(w);
            for (int k = 0; k < 8; k++) begin
               @(negedge clk);
               if (rst_int || !sys_clk_en) bad++;
            end
            chk("R5 short pulse ignored", bad, 0);
         end else begin
            ext_pulse(w);
            measure(0, 0, n);
            chk("R6 stable skip release", n, SYNC + 1 + S);
            chk("R6 window low", int'(n - 1 >= 192), 1);
            chk("R6 window high", int'(n - 1 <= 196), 1);
         end
      end

      // R12, R8, R13: flag clear, low-voltage reset, sleep during reset
      por_flag_clr = 1'b1;
      tick(1);
      por_flag_clr = 1'b0;
      chk("R12 flag cleared", int'(por_flag), 0);
      lvr_req = 1'b1;
      tick(1);
      chk("R8 lvr asserts rst", int'(rst_int), 1);
      sleep_mode = 2'b11;
      sleep_req  = 1'b1;
      tick(1);
      sleep_req  = 1'b0;
      tick(1);
      lvr_req = 1'b0;
      measure(0, 0, n);
      chk("R8 lvr release with check", n, 1 + P + S);
      chk("R12 flag stays clear", int'(por_flag), 0);
      tick(3);
      chk("R13 sleep during reset ignored", int'(sys_clk_en), 1);
      sleep_mode = 2'b00;
      sleep_req  = 1'b1;
      tick(1);
      sleep_req  = 1'b0;
      chk("R13 mode none ignored", int'(sys_clk_en), 1);

      // R9, R10, R11: every mode against every wake line
      for (int m = 1; m <= 3; m++) begin
         for (int w = 0; w <= 2; w++) begin
            string tag;
            int    acc;
            tag = (m == 1) ? "R9" : (m == 2) ? "R10" : "R11";
            acc = (m == 1 && w == 2) ? 0 : 1;
            sleep_mode = 2'(m);
            sleep_req  = 1'b1;
            tick(1);
            sleep_req  = 1'b0;
            chk({tag, " sleep clk off"}, int'(sys_clk_en), 0);
            chk({tag, " sleep vreg"}, int'(vreg_fpm_req), (m == 3) ? 1 : 0);
            if (w == 0) wake_ext_irq = 1'b1;
            if (w == 1) wake_periodic = 1'b1;
            if (w == 2) wake_int_irq = 1'b1;
            tick(1);
            wake_ext_irq = 1'b0; wake_periodic = 1'b0; wake_int_irq = 1'b0;
            if (m == 3) begin
               chk({tag, " doze wake clk"}, int'(sys_clk_en), acc);
               chk({tag, " doze vreg kept"}, int'(vreg_fpm_req), 1);
            end else begin
               chk({tag, " wake vreg request"}, int'(vreg_fpm_req), acc);
               chk({tag, " clk waits"}, int'(sys_clk_en), 0);
               if (acc == 0) begin
                  wake_ext_irq = 1'b1;
                  tick(1);
                  wake_ext_irq = 1'b0;
                  chk({tag, " ext wake after ignored int"}, int'(vreg_fpm_req), 1);
               end
               tick(2);
               chk({tag, " waits for ready"}, int'(sys_clk_en), 0);
               vreg_ready = 1'b1;
               n = -1;
               for (int i = 1; i <= 100; i++) begin
                  @(negedge clk);
                  if (sys_clk_en) begin
                     n = i;
                     break;
                  end
               end
               vreg_ready = 1'b0;
               chk({tag, " recovery cycles"}, n, (m == 1) ? 1 + P : 1);
               chk({tag, " no reset on wake"}, int'(rst_int), 0);
            end
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule